// File: doc/BRIEF.md
# SFP Module Status Monitor

This block watches one pluggable optical module cage. Three module pins (receive loss of signal, transmit fault, module absent) and the link indication from the attached 1G PHY arrive with no relation to the local clock. Each is passed through a flop synchronizer. The block presents the results as one 32-bit status word.

Next to each live module pin level, the word carries a sticky "changed since last read" flag. Software polls the word and pulses a read strobe when it takes a value. That pulse clears the flags. A transition that arrives in the same cycle as the read keeps its flag, so no insertion, removal or fault event is lost between polls. A combined interrupt reports that at least one flag is pending. A "module healthy" output tells link bring-up logic when it may start.

Top module: `sfp_status_mon`

## Requirements
- R1: status_o bit 0 shows receive loss of signal, bit 1 shows transmit fault and bit 2 shows module absent. Each is the pin level sampled at a rising edge and becomes visible after the second rising edge (two-flop synchronizer).
- R2: Bits 3, 4 and 5 are change flags for bits 0, 1 and 2. A flag sets one cycle after its state bit changes in either direction, and it stays set with no read.
- R3: While rd_i is high, status_o still shows the current flags. After the next rising edge, every flag with no new change is 0.
- R4: If a state bit changes in the same cycle that rd_i is high, its flag is 1 after that edge.
- R5: status_o bit 16 shows link_up_i through the same two-flop synchronizer, with no change flag. Bits 6 to 15 and 17 to 31 are always 0.
- R6: mod_ok_o is 1 exactly when bits 0, 1 and 2 of status_o are all 0.
- R7: irq_o is 1 exactly when any of bits 3 to 5 of status_o is set.
- R8: After reset all flags are 0 and stay 0 while the synchronizers fill with the pin levels held through reset. The state bits then show those levels.
- R9: A change on one pin sets only its own flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_los_i | input | 1 | Module receive loss of signal (asynchronous) |
| tx_fault_i | input | 1 | Module transmit fault (asynchronous) |
| mod_abs_i | input | 1 | Module absent, high when the cage is empty (asynchronous) |
| link_up_i | input | 1 | PHY link indication (asynchronous) |
| rd_i | input | 1 | Read strobe; clears the change flags |
| status_o | output | 32 | Status word |
| mod_ok_o | output | 1 | All three module pins low |
| irq_o | output | 1 | At least one change flag set |

## Verification
The bench first holds mixed pin levels through reset. This separates correct arming from spurious flags raised while the synchronizers fill. It then drives insertion, removal and fault toggles one pin at a time, which tells whether each flag follows its own pin or a neighbour. Short two-cycle glitches show that a pulse leaving and returning still counts as a change. A read aligned with the cycle in which a transition is detected tells a clean clear apart from a lost event. Link toggles and long stretches with no read confirm that bit 16 carries no flag and that flags persist.

// File: rtl/sfp_mon_pkg.sv
package sfp_mon_pkg;
  localparam int NUM_PINS  = 3;
  localparam int PIN_RX    = 0;
  localparam int PIN_TX    = 1;
  localparam int PIN_ABS   = 2;
  localparam int STAT_W    = 32;
  localparam int FLAG_LSB  = NUM_PINS;
  localparam int LINK_BIT  = 16;
  localparam int SYNC_W    = NUM_PINS + 1;
endpackage

// File: rtl/sfp_mon_sync.sv
module sfp_mon_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfp_mon_arm.sv
module sfp_mon_arm #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic armed_o
);
  logic [DEPTH-1:0] fill_q;

  // Holds off edge detection until synchronizer and history are primed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[DEPTH-2:0], 1'b1};
  end

  assign armed_o = fill_q[DEPTH-1];
endmodule

// File: rtl/sfp_mon_sticky.sv
module sfp_mon_sticky #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         arm_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] chg;

  assign chg = arm_i ? (lvl_i ^ prev_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // set wins over clear so a coincident event survives the read
      flag_q <= (clr_i ? '0 : flag_q) | chg;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sfp_status_mon.sv
module sfp_status_mon
  import sfp_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_los_i,
  input  logic              tx_fault_i,
  input  logic              mod_abs_i,
  input  logic              link_up_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              mod_ok_o,
  output logic              irq_o
);
  localparam int ARM_DEPTH = SYNC_STAGES + 1;

  logic [SYNC_W-1:0]   raw;
  logic [SYNC_W-1:0]   synced;
  logic [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] flags;
  logic                armed;

  assign raw[PIN_RX]   = rx_los_i;
  assign raw[PIN_TX]   = tx_fault_i;
  assign raw[PIN_ABS]  = mod_abs_i;
  assign raw[NUM_PINS] = link_up_i;

  sfp_mon_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  sfp_mon_arm #(.DEPTH(ARM_DEPTH)) u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_o(armed)
  );

  assign pin_lvl = synced[NUM_PINS-1:0];

  sfp_mon_sticky #(.W(NUM_PINS)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_lvl),
    .arm_i (armed),
    .clr_i (rd_i),
    .flag_o(flags)
  );

  always_comb begin
    status_o = '0;
    status_o[NUM_PINS-1:0]                 = pin_lvl;
    status_o[FLAG_LSB +: NUM_PINS]         = flags;
    status_o[LINK_BIT]                     = synced[NUM_PINS];
  end

  assign mod_ok_o = ~|pin_lvl;
  assign irq_o    = |flags;
endmodule

// File: rtl/sfp_status_mon_chk.sv
module sfp_status_mon_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic [31:0] status_o,
  input logic        mod_ok_o,
  input logic        irq_o
);
  logic [2:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
  end

  for (genvar i = 0; i < 3; i++) begin : g_pin
    assert_flag_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[3+i] && !rd_i |=> status_o[3+i]);
    assert_read_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i && $stable(status_o[i]) |=> !status_o[3+i]);
    assert_change_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst_q >= 3'd4) && !$stable(status_o[i]) |=> status_o[3+i]);
  end

  assert_quiet_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < 3'd3) |-> status_o[5:3] == 3'b000);

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:6] == '0 && status_o[31:17] == '0);

  assert_healthy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_ok_o == (status_o[2:0] == 3'b000));

  assert_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[5:3] != 3'b000));
endmodule

bind sfp_status_mon sfp_status_mon_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .status_o(status_o),
  .mod_ok_o(mod_ok_o),
  .irq_o   (irq_o)
);

// File: tb/tb_sfp_status_mon.sv
`timescale 1ns/1ps
module tb_sfp_status_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_los = 1'b1, tx_fault = 1'b0, mod_abs = 1'b1, link_up = 1'b0, rd = 1'b0;
  logic [31:0] status;
  logic        mod_ok, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sfp_status_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_los_i(rx_los), .tx_fault_i(tx_fault),
    .mod_abs_i(mod_abs), .link_up_i(link_up), .rd_i(rd),
    .status_o(status), .mod_ok_o(mod_ok), .irq_o(irq)
  );

  // behavioural reference: history of sampled pins, newest first
  logic [3:0] hist[$];
  int         edges = 0;
  logic [2:0] m_flags = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0;
      hist.delete();
      m_flags = '0;
    end else begin
      logic [2:0] chg;
      edges++;
      hist.push_front({link_up, mod_abs, tx_fault, rx_los});
      chg = (edges >= 4) ? (hist[2][2:0] ^ hist[3][2:0]) : 3'b000;
      m_flags = (rd ? 3'b000 : m_flags) | chg;
      if (hist.size() > 6) void'(hist.pop_back());
    end
  end

  function automatic logic [3:0] m_sync();
    return (edges >= 2) ? hist[1] : 4'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] s;
      s = m_sync();
      chk("R1 state bits", {29'd0, status[2:0]}, {29'd0, s[2:0]});
      chk("R2 change flags", {29'd0, status[5:3]}, {29'd0, m_flags});
      chk("R5 link/reserved", {status[31:6], 6'd0}, {15'd0, s[3], 16'd0});
      chk("R6 mod_ok", {31'd0, mod_ok}, {31'd0, (s[2:0] == 3'b000)});
      chk("R7 irq", {31'd0, irq}, {31'd0, (m_flags != 3'b000)});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R8 reset status", status, 32'h0);
    rst_n = 1'b1;
    cyc(8);
    // R8: pins held through reset give no flag; R1 levels visible
    chk("R8 no spurious flag", {29'd0, status[5:3]}, 32'd0);
    chk("R1 levels after reset", {29'd0, status[2:0]}, 32'd5);

    // insertion: module absent goes low
    mod_abs = 1'b0;
    cyc(2);
    chk("R1 abs low after two edges", {31'd0, status[2]}, 32'd0);
    chk("R2 flag not yet", {31'd0, status[5]}, 32'd0);
    cyc(1);
    chk("R2 abs flag set", {31'd0, status[5]}, 32'd1);
    chk("R9 other flags clear", {30'd0, status[4:3]}, 32'd0);
    chk("R7 irq on flag", {31'd0, irq}, 32'd1);
    cyc(20);
    chk("R2 flag persists", {31'd0, status[5]}, 32'd1);

    // read: value visible in the read cycle, cleared after
    rd = 1'b1;
    chk("R3 flag visible during read", {31'd0, status[5]}, 32'd1);
    cyc(1);
    rd = 1'b0;
    chk("R3 cleared after read", {29'd0, status[5:3]}, 32'd0);

    // rx loss clears -> module healthy
    rx_los = 1'b0;
    cyc(4);
    chk("R6 healthy", {31'd0, mod_ok}, 32'd1);
    chk("R9 rx flag only", {29'd0, status[5:3]}, 32'd1);
    read_pulse();

    // R4: transition detected in the same cycle as the read
    tx_fault = 1'b1;
    cyc(2);
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    chk("R4 coincident flag kept", {31'd0, status[4]}, 32'd1);
    chk("R6 unhealthy on fault", {31'd0, mod_ok}, 32'd0);
    read_pulse();

    // short glitch on rx loss (two cycles high)
    rx_los = 1'b1;
    cyc(2);
    rx_los = 1'b0;
    cyc(6);
    chk("R2 glitch flagged", {31'd0, status[3]}, 32'd1);
    read_pulse();

    // link toggles: no flag
    link_up = 1'b1;
    cyc(4);
    chk("R5 link bit", {31'd0, status[16]}, 32'd1);
    chk("R5 link has no flag", {29'd0, status[5:3]}, 32'd0);
    link_up = 1'b0;
    cyc(4);

    // removal and several pins together
    mod_abs = 1'b1;
    tx_fault = 1'b0;
    cyc(5);
    chk("R9 two flags", {29'd0, status[5:3]}, 32'd6);
    read_pulse();
    cyc(3);

    // mixed pattern sweep against the model
    for (int i = 0; i < 64; i++) begin
      {link_up, mod_abs, tx_fault, rx_los} = 4'(i * 7 + 3);
      rd = (i % 5 == 0);
      cyc(1 + (i % 3));
    end
    rd = 1'b0;
    cyc(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule